// File: doc/BRIEF.md
# Segmented Activation Network

This block works out which elements of an N-element processing string become active for the next operation. Each element contributes a match tag and a destination tag. A one-bit signal starts at a matching element, or is injected at a string end, and travels left or right along the string. The selected option turns that signal into a new activation vector. Programmable links sit at the boundaries between neighbouring elements and split the string into segments. A signal can never pass an open link, so each segment works on its own.

The controller strobes a command carrying an option code, a direction and an include-source bit. The activation vector is captured in a register on that same clock edge. Also captured is the value that came out of the far end of the string. The link register can be loaded one boundary at a time. A single command can also set it up as equal segments whose length is a power of two. The path from tags to the next activation value is purely combinational. Each command therefore costs one clock.

Top module: `segact_net`

## Requirements
- R1: While `rst_n` is low on a clock edge, the next state has `act_q`, `lsense_q`, `rsense_q` and every bit of `link_q` at 0. A link bit of 0 means the link is closed.
- R2: Option code 0 loads `act_q` with `m_tag`. Option code 1 loads `act_q` with the bitwise inverse of `m_tag`.
- R3: Option code 2 (neighbour) activates each element whose upstream neighbour carries a match tag, provided the boundary between them is closed. The first element in the direction of travel takes the injected port value instead.
- R4: Option code 3 (remote) sends a signal from each matching element, and from the injecting port. The signal runs downstream until it reaches the first element whose destination tag is set, and that element is activated. The signal stops earlier if it meets an open link or the string end. An element with a match tag sends its own signal whatever its destination tag.
- R5: Option code 4 (between) pairs the signal sources inside each segment, counting the injecting port first when it is in the leftmost upstream segment. Every element after an opening source and before the next source is activated. The opening source is also activated when `cmd_incl` is 1. The closing source is never activated.
- R6: Option code 5 (to end) activates every element downstream of the first source in its segment, up to the segment's end. When `cmd_incl` is 1, every matching element is activated as well.
- R7: `cmd_left` = 0 sends signals toward higher indices, with `lport_in` injected before element 0. `cmd_left` = 1 sends signals toward lower indices, with `rport_in` injected beyond element N-1.
- R8: Link bit i sits between element i and element i+1. The value 1 (open) blocks every signal crossing that boundary, and 0 lets it pass.
- R9: On a strobe, the sense flag at the downstream end takes the signal leaving the last element. The signal leaving is: the match tag of that element for neighbour; an unconsumed signal for remote; odd parity for between; any source for to end. The upstream sense flag takes 0. Option codes 0, 1, 6 and 7 give 0 on both sense flags.
- R10: When `link_wr` is 1, `link_q` takes `link_wr_val` on the next edge.
- R11: When `seg_cmd` is 1 and `link_wr` is 0, link i opens exactly when (i+1) is a multiple of 2^`seg_log`. A value of 0 opens every link. Any value of at least log2(N) closes every link.
- R12: Without `cmd_valid`, `act_q` and both sense flags hold their values. Option codes 6 and 7 load an all-zero activation.
- R13: A command strobed in the same cycle as a link update uses the link state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_tag | input | N | Match tags, one per element |
| d_tag | input | N | Destination tags, one per element |
| cmd_valid | input | 1 | Command strobe |
| cmd_opt | input | 3 | Activation option code |
| cmd_left | input | 1 | 1 sends signals toward index 0 |
| cmd_incl | input | 1 | Include first source (between / to end) |
| lport_in | input | 1 | Signal injected at the left string end |
| rport_in | input | 1 | Signal injected at the right string end |
| link_wr | input | 1 | Write link register |
| link_wr_val | input | N-1 | Per-boundary link values, 1 = open |
| seg_cmd | input | 1 | Set equal power-of-two segments |
| seg_log | input | clog2(log2(N)+1) | log2 of the segment length |
| act_q | output | N | Registered activation vector |
| lsense_q | output | 1 | Registered signal sensed at the left end |
| rsense_q | output | 1 | Registered signal sensed at the right end |
| link_q | output | N-1 | Current link state |

## Verification
The link state is held in a register and is brought out on `link_q`. A corrupted link bit therefore shows up at the port on the clock after the write that caused it. It also changes the activation of the next command that crosses that boundary. The activation and sense registers change only on a strobe. A wrong carry in the propagation chain therefore shows on `act_q` or on a sense flag one clock after the command. Errors in the reversal used for leftward travel show up as mirrored activation patterns, which only leftward commands expose.

// File: rtl/segact_pkg.sv
// Package: option codes shared by the activation network and its parts.
package segact_pkg;
    typedef enum logic [2:0] {
        OPT_MATCH   = 3'd0,
        OPT_MISS    = 3'd1,
        OPT_NEIGH   = 3'd2,
        OPT_REMOTE  = 3'd3,
        OPT_BETWEEN = 3'd4,
        OPT_TOEND   = 3'd5
    } act_opt_e;
endpackage

// File: rtl/segact_links.sv
// Link register: one bit per boundary between neighbouring elements (1 = open).
// A per-boundary write has priority over the power-of-two segment command.
// Assumes N >= 2.
module segact_links #(
    parameter int N     = 16,
    parameter int LOG_N = $clog2(N),
    parameter int KW    = $clog2(LOG_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [N-2:0]  wr_val,
    input  logic          pow_en,
    input  logic [KW-1:0] pow_log,
    output logic [N-2:0]  link_q
);
    logic [N-2:0] pat;

    // Equal-segment pattern: boundary i is open when (i+1) is a multiple of the length.
    for (genvar i = 0; i < N - 1; i++) begin : g_pat
        assign pat[i] = (int'(pow_log) < LOG_N) && (((i + 1) % (1 << pow_log)) == 0);
    end

    // Link state update.
    always_ff @(posedge clk) begin
        if (!rst_n)      link_q <= '0;
        else if (wr_en)  link_q <= wr_val;
        else if (pow_en) link_q <= pat;
    end

    p_reset_closed_r1: assert property (@(posedge clk) !rst_n |=> (link_q == '0));
    p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (link_q == $past(wr_val)));
    p_unit_segments_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pow_en && !wr_en && pow_log == '0) |=> (&link_q));
endmodule

// File: rtl/segact_chain.sv
// Propagation chain: a one-bit signal walks from index 0 upward, is cleared by
// any open boundary in front of an element, and is shaped by the option code.
// Works in logical (travel) order; the caller mirrors vectors for leftward travel.
module segact_chain
    import segact_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] dst,
    input  logic [N-2:0] opn,
    input  logic [2:0]   opt,
    input  logic         incl,
    input  logic         pin,
    output logic [N-1:0] act,
    output logic         pout
);
    logic [N-1:0] brk;
    assign brk = {opn, 1'b0};

    // Ripple the signal along the string and derive each element's activation.
    always_comb begin
        logic c;
        c   = pin;
        act = '0;
        for (int i = 0; i < N; i++) begin
            if (brk[i]) c = 1'b0;
            case (opt)
                OPT_MATCH:   begin act[i] = src[i];  c = 1'b0; end
                OPT_MISS:    begin act[i] = ~src[i]; c = 1'b0; end
                OPT_NEIGH:   begin act[i] = c; c = src[i]; end
                OPT_REMOTE:  begin act[i] = c & dst[i]; c = src[i] | (c & ~dst[i]); end
                OPT_BETWEEN: begin
                    act[i] = (c & ~src[i]) | (incl & src[i] & ~c);
                    c      = c ^ src[i];
                end
                OPT_TOEND:   begin act[i] = c | (incl & src[i]); c = c | src[i]; end
                default:     begin act[i] = 1'b0; c = 1'b0; end
            endcase
        end
        pout = c;
    end
endmodule

// File: rtl/segact_net.sv
// Segmented activation network top: mirrors the tags and links for leftward
// travel, runs the chain, and registers the activation and end-sense values on
// a command strobe. Link updates in the same cycle take effect afterwards.
module segact_net
    import segact_pkg::*;
#(
    parameter int N     = 16,
    parameter int LOG_N = $clog2(N),
    parameter int KW    = $clog2(LOG_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  m_tag,
    input  logic [N-1:0]  d_tag,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_opt,
    input  logic          cmd_left,
    input  logic          cmd_incl,
    input  logic          lport_in,
    input  logic          rport_in,
    input  logic          link_wr,
    input  logic [N-2:0]  link_wr_val,
    input  logic          seg_cmd,
    input  logic [KW-1:0] seg_log,
    output logic [N-1:0]  act_q,
    output logic          lsense_q,
    output logic          rsense_q,
    output logic [N-2:0]  link_q
);
    logic [N-1:0] m_rev, d_rev, act_lg, act_rev, act_next;
    logic [N-2:0] link_rev;
    logic [N-1:0] c_src, c_dst;
    logic [N-2:0] c_opn;
    logic         c_pin, c_pout;

    segact_links #(.N(N), .LOG_N(LOG_N), .KW(KW)) u_links (
        .clk(clk), .rst_n(rst_n), .wr_en(link_wr), .wr_val(link_wr_val),
        .pow_en(seg_cmd), .pow_log(seg_log), .link_q(link_q)
    );

    // Mirrored views used when signals travel toward index 0.
    for (genvar i = 0; i < N; i++) begin : g_rev
        assign m_rev[i]   = m_tag[N-1-i];
        assign d_rev[i]   = d_tag[N-1-i];
        assign act_rev[i] = act_lg[N-1-i];
    end
    for (genvar j = 0; j < N - 1; j++) begin : g_rev_link
        assign link_rev[j] = link_q[N-2-j];
    end

    // Select travel order.
    assign c_src    = cmd_left ? m_rev    : m_tag;
    assign c_dst    = cmd_left ? d_rev    : d_tag;
    assign c_opn    = cmd_left ? link_rev : link_q;
    assign c_pin    = cmd_left ? rport_in : lport_in;
    assign act_next = cmd_left ? act_rev  : act_lg;

    segact_chain #(.N(N)) u_chain (
        .src(c_src), .dst(c_dst), .opn(c_opn), .opt(cmd_opt), .incl(cmd_incl),
        .pin(c_pin), .act(act_lg), .pout(c_pout)
    );

    // Capture activation and end-sense values on a command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            lsense_q <= 1'b0;
            rsense_q <= 1'b0;
        end else if (cmd_valid) begin
            act_q    <= act_next;
            lsense_q <= cmd_left & c_pout;
            rsense_q <= ~cmd_left & c_pout;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (act_q == '0 && !lsense_q && !rsense_q));
    p_match_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opt == OPT_MATCH) |=> (act_q == $past(m_tag)));
    p_miss_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opt == OPT_MISS) |=> (act_q == ~$past(m_tag)));
    p_neigh_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opt == OPT_NEIGH) |=> ($countones(act_q) <= $countones($past(m_tag)) + 1));
    p_remote_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opt == OPT_REMOTE) |=> ((act_q & ~$past(d_tag)) == '0));
    p_upstream_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> ($past(cmd_left) ? !rsense_q : !lsense_q));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(act_q) && $stable(lsense_q) && $stable(rsense_q)));
    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opt > 3'd5) |=> (act_q == '0 && !lsense_q && !rsense_q));
endmodule

// File: tb/tb_segact_net.sv
`timescale 1ns/1ps
// Bench: behavioural search-based reference model, compared on every clock.
module tb_segact_net;
    localparam int N     = 16;
    localparam int LOG_N = $clog2(N);
    localparam int KW    = $clog2(LOG_N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] m_tag = '0, d_tag = '0;
    logic cmd_valid = 1'b0, cmd_left = 1'b0, cmd_incl = 1'b0;
    logic [2:0] cmd_opt = '0;
    logic lport_in = 1'b0, rport_in = 1'b0;
    logic link_wr = 1'b0, seg_cmd = 1'b0;
    logic [N-2:0] link_wr_val = '0;
    logic [KW-1:0] seg_log = '0;
    logic [N-1:0] act_q;
    logic lsense_q, rsense_q;
    logic [N-2:0] link_q;

    always #2.5 clk = ~clk;

    segact_net #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .m_tag(m_tag), .d_tag(d_tag), .cmd_valid(cmd_valid),
        .cmd_opt(cmd_opt), .cmd_left(cmd_left), .cmd_incl(cmd_incl), .lport_in(lport_in),
        .rport_in(rport_in), .link_wr(link_wr), .link_wr_val(link_wr_val), .seg_cmd(seg_cmd),
        .seg_log(seg_log), .act_q(act_q), .lsense_q(lsense_q), .rsense_q(rsense_q), .link_q(link_q)
    );

    int n_chk = 0, n_err = 0;
    string tag = "R1", e_tag = "R1";
    logic [N-1:0] e_act = '0;
    logic e_ls = 1'b0, e_rs = 1'b0;
    logic [N-2:0] e_link = '0;
    logic started = 1'b0;

    // Reference evaluation by explicit searches over the string in travel order.
    function automatic void ref_eval(input logic [N-1:0] m, input logic [N-1:0] d,
                                     input logic [N-2:0] lk, input logic [2:0] opt,
                                     input logic left, input logic incl,
                                     input logic lin, input logic rin,
                                     output logic [N-1:0] act, output logic ls, output logic rs);
        logic [N-1:0] lm, ld, lopen, la;
        logic pin, sense;
        int st, cnt;
        lopen = '0; la = '0; sense = 1'b0;
        for (int j = 0; j < N; j++) begin
            lm[j] = left ? m[N-1-j] : m[j];
            ld[j] = left ? d[N-1-j] : d[j];
        end
        for (int j = 0; j < N - 1; j++) lopen[j] = left ? lk[N-2-j] : lk[j];
        pin = left ? rin : lin;
        for (int j = 0; j < N; j++) begin
            st = j;
            while (st > 0 && !lopen[st-1]) st--;
            cnt = (st == 0 && pin) ? 1 : 0;
            for (int k = st; k < j; k++) cnt += int'(lm[k]);
            case (opt)
                3'd0: la[j] = lm[j];
                3'd1: la[j] = ~lm[j];
                3'd2: la[j] = (j == 0) ? pin : (lm[j-1] && !lopen[j-1]);
                3'd4: la[j] = lm[j] ? (incl && (cnt % 2 == 0)) : (cnt % 2 == 1);
                3'd5: la[j] = (cnt > 0) || (incl && lm[j]);
                default: la[j] = 1'b0;
            endcase
        end
        st = N - 1;
        while (st > 0 && !lopen[st-1]) st--;
        cnt = (st == 0 && pin) ? 1 : 0;
        for (int k = st; k < N; k++) cnt += int'(lm[k]);
        case (opt)
            3'd2: sense = lm[N-1];
            3'd4: sense = (cnt % 2 == 1);
            3'd5: sense = (cnt > 0);
            default: sense = 1'b0;
        endcase
        if (opt == 3'd3) begin
            for (int s = -1; s < N; s++) begin
                if ((s < 0) ? pin : lm[s]) begin
                    int k;
                    logic run;
                    k = s + 1; run = 1'b1;
                    while (run && k < N) begin
                        if (k > 0 && lopen[k-1]) run = 1'b0;
                        else if (ld[k]) begin la[k] = 1'b1; run = 1'b0; end
                        else k++;
                    end
                    if (run) sense = 1'b1;
                end
            end
        end
        for (int j = 0; j < N; j++) act[j] = left ? la[N-1-j] : la[j];
        ls = left & sense;
        rs = ~left & sense;
    endfunction

    // Model state update at each rising edge, from the inputs set at the last falling edge.
    always @(posedge clk) begin
        logic [N-1:0] a;
        logic l, r;
        started = 1'b1;
        e_tag = tag;
        if (!rst_n) begin
            e_act = '0; e_ls = 1'b0; e_rs = 1'b0; e_link = '0;
        end else begin
            if (cmd_valid) begin
                ref_eval(m_tag, d_tag, e_link, cmd_opt, cmd_left, cmd_incl, lport_in, rport_in, a, l, r);
                e_act = a; e_ls = l; e_rs = r;
            end
            if (link_wr) e_link = link_wr_val;
            else if (seg_cmd) begin
                for (int i = 0; i < N - 1; i++)
                    e_link[i] = (int'(seg_log) < LOG_N) &&
                                (((i + 1) / (1 << seg_log)) * (1 << seg_log) == i + 1);
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", e_tag, what, act, exp);
        end
    endtask

    // Compare all outputs on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            check("act_q", 32'(act_q), 32'(e_act));
            check("lsense_q", 32'(lsense_q), 32'(e_ls));
            check("rsense_q", 32'(rsense_q), 32'(e_rs));
            check("link_q", 32'(link_q), 32'(e_link));
        end
    end

    task automatic cmd(input string t, input logic [2:0] o, input logic lf, input logic inc,
                       input logic [N-1:0] m, input logic [N-1:0] d, input logic li, input logic ri);
        @(negedge clk);
        tag = t; cmd_valid = 1'b1; cmd_opt = o; cmd_left = lf; cmd_incl = inc;
        m_tag = m; d_tag = d; lport_in = li; rport_in = ri;
        link_wr = 1'b0; seg_cmd = 1'b0;
    endtask

    task automatic idle(input string t);
        @(negedge clk);
        tag = t; cmd_valid = 1'b0; link_wr = 1'b0; seg_cmd = 1'b0;
    endtask

    task automatic wr_links(input string t, input logic [N-2:0] v);
        @(negedge clk);
        tag = t; cmd_valid = 1'b0; link_wr = 1'b1; link_wr_val = v; seg_cmd = 1'b0;
    endtask

    task automatic seg(input string t, input logic [KW-1:0] k);
        @(negedge clk);
        tag = t; cmd_valid = 1'b0; link_wr = 1'b0; seg_cmd = 1'b1; seg_log = k;
    endtask

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");
        // R2: match and mismatch copies.
        cmd("R2", 3'd0, 1'b0, 1'b0, 16'hA5C3, '0, 1'b0, 1'b0);
        cmd("R2", 3'd1, 1'b0, 1'b0, 16'hA5C3, '0, 1'b0, 1'b0);
        // R3: neighbours with port injection, both directions.
        cmd("R3", 3'd2, 1'b0, 1'b0, 16'h8011, '0, 1'b1, 1'b0);
        cmd("R3", 3'd2, 1'b1, 1'b0, 16'h8011, '0, 1'b0, 1'b1);
        // R4: remote destinations.
        cmd("R4", 3'd3, 1'b0, 1'b0, 16'h0102, 16'h1044, 1'b1, 1'b0);
        cmd("R4", 3'd3, 1'b1, 1'b0, 16'h0400, 16'h0000, 1'b0, 1'b0);
        // R5: between, with and without the opening source.
        cmd("R5", 3'd4, 1'b0, 1'b0, 16'h0910, '0, 1'b0, 1'b0);
        cmd("R5", 3'd4, 1'b0, 1'b1, 16'h0910, '0, 1'b0, 1'b0);
        // R6: to the end of the string.
        cmd("R6", 3'd5, 1'b0, 1'b1, 16'h0020, '0, 1'b0, 1'b0);
        // R7: leftward travel from the right port.
        cmd("R7", 3'd5, 1'b1, 1'b0, 16'h0000, '0, 1'b0, 1'b1);
        cmd("R7", 3'd4, 1'b1, 1'b1, 16'h0210, '0, 1'b0, 1'b0);
        // R10 and R8: one open link splits the string.
        wr_links("R10", 15'h0080);
        cmd("R8", 3'd5, 1'b0, 1'b0, 16'h0008, '0, 1'b0, 1'b0);
        cmd("R8", 3'd3, 1'b1, 1'b0, 16'h0400, 16'h0001, 1'b0, 1'b0);
        // R9: sense flags at each end.
        cmd("R9", 3'd3, 1'b0, 1'b0, 16'h0200, 16'h0000, 1'b0, 1'b0);
        cmd("R9", 3'd2, 1'b1, 1'b0, 16'h0001, '0, 1'b0, 1'b0);
        // R11: power-of-two segments.
        seg("R11", 3'd2);
        cmd("R11", 3'd5, 1'b0, 1'b0, 16'h1111, '0, 1'b0, 1'b0);
        seg("R11", 3'd0);
        cmd("R11", 3'd3, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
        seg("R11", 3'd4);
        seg("R11", 3'd7);
        // R12: hold without strobe, reserved codes zero.
        cmd("R12", 3'd0, 1'b0, 1'b0, 16'h3C3C, '0, 1'b0, 1'b0);
        idle("R12");
        @(negedge clk); m_tag = 16'hFFFF; cmd_opt = 3'd1;
        idle("R12");
        cmd("R12", 3'd6, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        cmd("R12", 3'd7, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        // R13: link write and command in the same cycle.
        seg("R13", 3'd4);
        @(negedge clk);
        tag = "R13"; cmd_valid = 1'b1; cmd_opt = 3'd5; cmd_left = 1'b0; cmd_incl = 1'b0;
        m_tag = 16'h0001; link_wr = 1'b1; link_wr_val = 15'h0004; seg_cmd = 1'b0;
        cmd("R13", 3'd5, 1'b0, 1'b0, 16'h0001, '0, 1'b0, 1'b0);
        // Randomized mix across all options, directions and link states.
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            cmd_opt   = 3'($urandom_range(0, 7));
            tag       = tag_of(cmd_opt);
            cmd_valid = ($urandom_range(0, 9) < 8);
            if (!cmd_valid) tag = "R12";
            cmd_left  = 1'($urandom);
            cmd_incl  = 1'($urandom);
            m_tag     = N'($urandom) & N'($urandom);
            d_tag     = N'($urandom) & N'($urandom);
            lport_in  = 1'($urandom);
            rport_in  = 1'($urandom);
            link_wr   = ($urandom_range(0, 9) == 0);
            link_wr_val = (N-1)'($urandom) & (N-1)'($urandom) & (N-1)'($urandom);
            seg_cmd   = ($urandom_range(0, 9) == 0);
            seg_log   = KW'($urandom);
        end
        idle("R12");
        idle("R12");
        // R1: reset again mid-run.
        @(negedge clk); tag = "R1"; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle("R1");
        idle("R1");
        report();
    end
endmodule